// File: doc/BRIEF.md
# External Memory Strobe Timing Generator

This block runs one access to external memory at a time. A requester raises `start` with a bank number and a read/write flag while `ready` is high. The block then copies that bank's timing word from `cfg_flat` and drives four controls: active-low chip-enable, active-low output-enable, active-low write-strobe, and an active-high enable for the write-data drivers. A memory-side `mem_wait` input can stretch an access, but only on banks that allow it. After each access the block keeps `ready` low for a programmable bus-release gap before it takes the next request.

`clk` is the phase clock. One clock period is one phase, and one memory cycle is two phases. Every edge position is a number of phases. The access length and the release gap are programmed in whole memory cycles, so they are doubled internally. The block keeps a phase counter, and each strobe edge is a comparison against it. Edge settings that fall outside the access are clamped to the access end, so every strobe is released by the end of its access.

Top module: `xmem_strobe_gen`

## Requirements
- R1: Per-bank word, LSB first: `[3:0]` dur, `[5:4]` rel, `[9:6]` ce_on, `[13:10]` ce_off, `[17:14]` oe_on, `[21:18]` we_on, `[25:22]` we_off, `[28:26]` drv_dly, `[29]` wait_en. Bank b occupies `cfg_flat[30*b +: 30]`. An accepted access runs len = 2*(dur+1) phases (0..len-1) if no wait cycles are added. `busy` is high for each of these phases, and `done` is high only in the final phase.
- R2: `start` is accepted only in a cycle where `ready` is high. A `start` raised while `busy` is high or while the release gap runs has no effect. Changes to `bank` or `wr` during an access do not affect that access.
- R3: `ce_n` is low in phase p exactly when min(ce_on,len) <= p < len - min(ce_off,len).
- R4: On reads, `oe_n` is low from phase min(oe_on,len) to the end of the access. On writes, `oe_n` stays high.
- R5: On writes, `we_n` is low exactly when min(we_on,len) <= p < len - min(we_off,len). On reads, `we_n` stays high.
- R6: On writes, `dq_oe` is high from phase min(drv_dly,len) to the end of the access. On reads, `dq_oe` stays low.
- R7: Settings larger than the access length are clamped, so a strobe may stay inactive for the whole access. Whenever `busy` is low, the strobes are inactive (`ce_n`, `oe_n` and `we_n` high, `dq_oe` low).
- R8: After the clock edge that ends an access, `ready` is low for exactly 2*rel clock cycles and then returns high.
- R9: If wait_en is set and `mem_wait` is high while the phase counter is at the hold phase, the counter does not advance. The hold phase is one less than the earliest deassert phase of chip-enable (and of write-strobe, on writes), with a floor of 0. The access grows by one phase for each held cycle, and `done` stays low while held.
- R10: If wait_en is clear, `mem_wait` has no effect on any output.
- R11: While `rst_n` is low, and after it is released, all strobes are inactive, `busy` and `done` are low, and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (two phases per memory cycle) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flat | input | 30*NUM_BANKS | Timing words of all banks |
| start | input | 1 | Access request |
| bank | input | BANK_W | Bank selected by the request |
| wr | input | 1 | 1 = write, 0 = read |
| mem_wait | input | 1 | Memory wait request |
| ready | output | 1 | A request is accepted in this cycle |
| busy | output | 1 | Access in progress |
| done | output | 1 | Final phase of the access |
| ce_n | output | 1 | Chip-enable, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 1 | Write-strobe, active low |
| dq_oe | output | 1 | Write-data drive enable |

## Verification
A `start` is sampled at a rising edge. Phase 0 is visible during the next clock period, and phase p is visible p periods later.

The strobes and `busy` come only from registered state. `done` also depends combinationally on `mem_wait` in the same cycle.

`ready` returns high 2*rel periods after the edge that ends the access.

The bench drives inputs on the falling edge and samples 1 ns later. It steps its own expected phase once per sample, holding it on cycles where the hold rule applies, so every comparison is made against the phase that is due in that cycle.

// File: rtl/xsg_pkg.sv
package xsg_pkg;
  localparam int DUR_W  = 4;
  localparam int REL_W  = 2;
  localparam int EDGE_W = 4;
  localparam int DRV_W  = 3;
  localparam int PH_W   = DUR_W + 2;
  localparam int NUM_STB = 4;

  typedef enum int {STB_CE = 0, STB_OE = 1, STB_WE = 2, STB_DV = 3} stb_idx_e;

  // One bank's timing word, MSB first.
  typedef struct packed {
    logic              wait_en;
    logic [DRV_W-1:0]  drv_dly;
    logic [EDGE_W-1:0] we_off;
    logic [EDGE_W-1:0] we_on;
    logic [EDGE_W-1:0] oe_on;
    logic [EDGE_W-1:0] ce_off;
    logic [EDGE_W-1:0] ce_on;
    logic [REL_W-1:0]  rel;
    logic [DUR_W-1:0]  dur;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  // Edge positions in phases, already clamped.
  typedef struct packed {
    logic [PH_W-1:0]  last;
    logic [PH_W-1:0]  ce_a;
    logic [PH_W-1:0]  ce_d;
    logic [PH_W-1:0]  oe_a;
    logic [PH_W-1:0]  we_a;
    logic [PH_W-1:0]  we_d;
    logic [PH_W-1:0]  dv_a;
    logic [PH_W-1:0]  hold;
    logic [REL_W:0]   rel_ph;
    logic             wait_en;
    logic             wr;
  } timing_t;
endpackage

// File: rtl/xsg_bank_decode.sv
module xsg_bank_decode
  import xsg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [NUM_BANKS*CFG_W-1:0] cfg_flat,
  input  logic [BANK_W-1:0]          bank,
  input  logic                       wr,
  output timing_t                    tim
);
  bank_cfg_t cfg_arr [NUM_BANKS];
  bank_cfg_t sel;
  logic [PH_W-1:0] len, ce_end, we_end, min_end;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_unpack
    assign cfg_arr[g] = cfg_flat[g*CFG_W +: CFG_W];
  end

  function automatic logic [PH_W-1:0] clamp_to(input logic [PH_W-1:0] v,
                                               input logic [PH_W-1:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  always_comb begin
    if (int'(bank) < NUM_BANKS) sel = cfg_arr[bank];
    else                        sel = '0;
    len     = PH_W'({sel.dur, 1'b0}) + PH_W'(2);
    ce_end  = len - clamp_to(PH_W'(sel.ce_off), len);
    we_end  = len - clamp_to(PH_W'(sel.we_off), len);
    min_end = (wr && (we_end < ce_end)) ? we_end : ce_end;

    tim.last    = len - PH_W'(1);
    tim.ce_a    = clamp_to(PH_W'(sel.ce_on), len);
    tim.ce_d    = ce_end;
    tim.oe_a    = clamp_to(PH_W'(sel.oe_on), len);
    tim.we_a    = clamp_to(PH_W'(sel.we_on), len);
    tim.we_d    = we_end;
    tim.dv_a    = clamp_to(PH_W'(sel.drv_dly), len);
    tim.hold    = (min_end == '0) ? '0 : min_end - PH_W'(1);
    tim.rel_ph  = {sel.rel, 1'b0};
    tim.wait_en = sel.wait_en;
    tim.wr      = wr;
  end
endmodule

// File: rtl/xsg_seq.sv
module xsg_seq
  import xsg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mem_wait,
  input  timing_t         tim_in,
  output timing_t         tim_q,
  output logic [PH_W-1:0] ph,
  output logic            busy,
  output logic            ready,
  output logic            done
);
  logic            busy_q, busy_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [REL_W:0]  rel_q, rel_d;
  logic            accept, stall, fin;
  logic            st_en, tim_en;

  always_comb begin
    ready  = !busy_q && (rel_q == '0);
    accept = start && ready;
    stall  = busy_q && tim_q.wait_en && mem_wait && (ph_q == tim_q.hold);
    fin    = busy_q && !stall && (ph_q == tim_q.last);
    busy_d = busy_q;
    ph_d   = ph_q;
    rel_d  = rel_q;
    tim_en = accept;
    if (accept) begin
      busy_d = 1'b1;
      ph_d   = '0;
    end else if (busy_q) begin
      if (fin) begin
        busy_d = 1'b0;
        rel_d  = tim_q.rel_ph;
      end else if (!stall) begin
        ph_d = ph_q + PH_W'(1);
      end
    end else if (rel_q != '0) begin
      rel_d = rel_q - 1'b1;
    end
    st_en = accept || busy_q || (rel_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      rel_q  <= '0;
    end else if (st_en) begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      rel_q  <= rel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tim_q <= '0;
    else if (tim_en) tim_q <= tim_in;
  end

  assign ph   = ph_q;
  assign busy = busy_q;
  assign done = fin;
endmodule

// File: rtl/xsg_edge_win.sv
module xsg_edge_win
  import xsg_pkg::*;
(
  input  logic            en,
  input  logic [PH_W-1:0] ph,
  input  logic [PH_W-1:0] on_ph,
  input  logic [PH_W-1:0] off_ph,
  output logic            act
);
  assign act = en && (ph >= on_ph) && (ph < off_ph);
endmodule

// File: rtl/xmem_strobe_gen.sv
module xmem_strobe_gen
  import xsg_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*CFG_W-1:0] cfg_flat,
  input  logic                       start,
  input  logic [BANK_W-1:0]          bank,
  input  logic                       wr,
  input  logic                       mem_wait,
  output logic                       ready,
  output logic                       busy,
  output logic                       done,
  output logic                       ce_n,
  output logic                       oe_n,
  output logic                       we_n,
  output logic                       dq_oe
);
  logic [1:0]      rst_pipe;
  logic            rst_i;
  timing_t         tim_new, tim_q;
  logic [PH_W-1:0] ph, len_q;
  logic [PH_W-1:0] on_arr  [NUM_STB];
  logic [PH_W-1:0] off_arr [NUM_STB];
  logic            en_arr  [NUM_STB];
  logic            act_arr [NUM_STB];

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  xsg_bank_decode #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) i_decode (
    .cfg_flat (cfg_flat),
    .bank     (bank),
    .wr       (wr),
    .tim      (tim_new)
  );

  xsg_seq i_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .start    (start),
    .mem_wait (mem_wait),
    .tim_in   (tim_new),
    .tim_q    (tim_q),
    .ph       (ph),
    .busy     (busy),
    .ready    (ready),
    .done     (done)
  );

  assign len_q = tim_q.last + PH_W'(1);

  always_comb begin
    on_arr[STB_CE]  = tim_q.ce_a;  off_arr[STB_CE] = tim_q.ce_d;  en_arr[STB_CE] = busy;
    on_arr[STB_OE]  = tim_q.oe_a;  off_arr[STB_OE] = len_q;       en_arr[STB_OE] = busy && !tim_q.wr;
    on_arr[STB_WE]  = tim_q.we_a;  off_arr[STB_WE] = tim_q.we_d;  en_arr[STB_WE] = busy && tim_q.wr;
    on_arr[STB_DV]  = tim_q.dv_a;  off_arr[STB_DV] = len_q;       en_arr[STB_DV] = busy && tim_q.wr;
  end

  for (genvar s = 0; s < NUM_STB; s++) begin : g_stb
    xsg_edge_win i_win (
      .en     (en_arr[s]),
      .ph     (ph),
      .on_ph  (on_arr[s]),
      .off_ph (off_arr[s]),
      .act    (act_arr[s])
    );
  end

  assign ce_n  = !act_arr[STB_CE];
  assign oe_n  = !act_arr[STB_OE];
  assign we_n  = !act_arr[STB_WE];
  assign dq_oe = act_arr[STB_DV];
endmodule

// File: rtl/xsg_checker.sv
module xsg_checker (
  input logic clk,
  input logic rst_i,
  input logic start,
  input logic ready,
  input logic busy,
  input logic done,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic dq_oe
);
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> (ce_n && oe_n && we_n && !dq_oe));

  assert_oe_we_excl_R5: assert property (@(posedge clk) disable iff (!rst_i)
    !(!oe_n && !we_n));

  assert_done_ends_R1: assert property (@(posedge clk) disable iff (!rst_i)
    done |=> !busy);

  assert_busy_until_done_R1: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !done) |=> busy);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (start && ready) |=> busy);

  assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (start && !ready && !busy) |=> !busy);

  assert_no_done_idle_R1: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> busy);
endmodule

bind xmem_strobe_gen xsg_checker i_xsg_checker (
  .clk   (clk),
  .rst_i (rst_i),
  .start (start),
  .ready (ready),
  .busy  (busy),
  .done  (done),
  .ce_n  (ce_n),
  .oe_n  (oe_n),
  .we_n  (we_n),
  .dq_oe (dq_oe)
);

// File: tb/test_xmem_strobe_gen.sv
module test_xmem_strobe_gen;
  localparam int NB = 4;
  localparam int CW = 30;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NB*CW-1:0] cfg_flat;
  logic          start, wr, mem_wait;
  logic [1:0]    bank;
  logic          ready, busy, done, ce_n, oe_n, we_n, dq_oe;

  int checks = 0;
  int errors = 0;
  bit all_done = 0;

  int b_dur[NB], b_rel[NB], b_ceon[NB], b_ceoff[NB], b_oeon[NB];
  int b_weon[NB], b_weoff[NB], b_drv[NB], b_wen[NB];

  always #5 clk = ~clk;

  xmem_strobe_gen #(.NUM_BANKS(NB)) i_xmem_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_flat(cfg_flat), .start(start), .bank(bank),
    .wr(wr), .mem_wait(mem_wait), .ready(ready), .busy(busy), .done(done),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int cl(input int v, input int lim);
    return (v > lim) ? lim : v;
  endfunction

  task automatic set_bank(input int b, input int dur, input int rel, input int ceon,
                          input int ceoff, input int oeon, input int weon,
                          input int weoff, input int drv, input int wen);
    b_dur[b] = dur; b_rel[b] = rel; b_ceon[b] = ceon; b_ceoff[b] = ceoff;
    b_oeon[b] = oeon; b_weon[b] = weon; b_weoff[b] = weoff; b_drv[b] = drv;
    b_wen[b] = wen;
    cfg_flat[b*CW +: CW] = {wen[0], drv[2:0], weoff[3:0], weon[3:0], oeon[3:0],
                            ceoff[3:0], ceon[3:0], rel[1:0], dur[3:0]};
  endtask

  task automatic check_idle(input string tag);
    chk(ce_n == 1'b1, {tag, " ce_n idle"}, ce_n, 1);
    chk(oe_n == 1'b1, {tag, " oe_n idle"}, oe_n, 1);
    chk(we_n == 1'b1, {tag, " we_n idle"}, we_n, 1);
    chk(dq_oe == 1'b0, {tag, " dq_oe idle"}, dq_oe, 0);
  endtask

  // One access, modelled phase by phase from the requirements.
  task automatic do_access(input int b, input bit w, input int wait_n,
                           input bit poke, input string tag);
    int len, ce_a, ce_d, oe_a, we_a, we_d, dv_a, hold, me, ep, s, r2;
    bit fin, stall_e;
    len  = 2 * (b_dur[b] + 1);
    ce_a = cl(b_ceon[b], len);  ce_d = len - cl(b_ceoff[b], len);
    oe_a = cl(b_oeon[b], len);
    we_a = cl(b_weon[b], len);  we_d = len - cl(b_weoff[b], len);
    dv_a = cl(b_drv[b], len);
    me   = (w && we_d < ce_d) ? we_d : ce_d;
    hold = (me == 0) ? 0 : me - 1;
    r2   = 2 * b_rel[b];

    @(negedge clk);
    bank = 2'(b); wr = w; start = 1'b1; mem_wait = 1'b0;
    #1 chk(ready == 1'b1, {tag, " R2 ready before start"}, ready, 1);
    @(negedge clk);
    ep = 0; s = 0; fin = 0;
    while (!fin && s < 300) begin
      start    = poke;
      if (poke) begin bank = 2'(b + 1); wr = !w; end
      mem_wait = (s < wait_n);
      #1;
      stall_e = (b_wen[b] != 0) && mem_wait && (ep == hold);
      chk(busy == 1'b1, {tag, " R1 busy"}, busy, 1);
      chk(done == (!stall_e && ep == len - 1), {tag, " R1/R9 done"}, done,
          int'(!stall_e && ep == len - 1));
      chk(ce_n == !(ep >= ce_a && ep < ce_d), {tag, " R3 ce_n"}, ce_n,
          int'(!(ep >= ce_a && ep < ce_d)));
      chk(oe_n == !(!w && ep >= oe_a), {tag, " R4 oe_n"}, oe_n, int'(!(!w && ep >= oe_a)));
      chk(we_n == !(w && ep >= we_a && ep < we_d), {tag, " R5 we_n"}, we_n,
          int'(!(w && ep >= we_a && ep < we_d)));
      chk(dq_oe == (w && ep >= dv_a), {tag, " R6 dq_oe"}, dq_oe, int'(w && ep >= dv_a));
      if (!stall_e) begin
        if (ep == len - 1) fin = 1;
        else ep++;
      end
      s++;
      @(negedge clk);
    end
    mem_wait = 1'b0;
    // Release gap (R8); a start raised here must be ignored (R2).
    for (int k = 0; k <= r2; k++) begin
      start = poke && (k < r2);
      #1;
      chk(busy == 1'b0, {tag, " R2 busy after end"}, busy, 0);
      chk(ready == (k == r2), {tag, " R8 ready in gap"}, ready, int'(k == r2));
      check_idle({tag, " R7"});
      if (k < r2) @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; wr = 1'b0; mem_wait = 1'b0; bank = '0; cfg_flat = '0;
    repeat (3) @(negedge clk);
    #1 check_idle("R11 in reset");
    chk(busy == 1'b0, "R11 busy in reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check_idle("R11 after reset");
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(done == 1'b0, "R11 done", done, 0);
    chk(ready == 1'b1, "R11 ready", ready, 1);
  endtask

  task automatic t_basic;     do_access(0, 1'b0, 0, 1'b0, "bank0 read");
                              do_access(0, 1'b1, 0, 1'b0, "bank0 write"); endtask
  task automatic t_clamp;     do_access(1, 1'b0, 0, 1'b0, "R7 clamp read");
                              do_access(1, 1'b1, 0, 1'b0, "R7 clamp write"); endtask
  task automatic t_wait;      do_access(0, 1'b1, 12, 1'b0, "R9 wait write");
                              do_access(0, 1'b0, 14, 1'b0, "R9 wait read");
                              do_access(2, 1'b1, 20, 1'b0, "R9 long write"); endtask
  task automatic t_wait_off;  do_access(3, 1'b0, 5, 1'b0, "R10 wait off");
                              do_access(1, 1'b1, 9, 1'b0, "R10 wait off wr"); endtask
  task automatic t_ignore;    do_access(0, 1'b0, 0, 1'b1, "R2 poke read");
                              do_access(3, 1'b1, 0, 1'b1, "R2 poke write"); endtask
  task automatic t_b2b;       do_access(1, 1'b0, 0, 1'b0, "R8 b2b a");
                              do_access(1, 1'b1, 0, 1'b0, "R8 b2b b");
                              do_access(2, 1'b0, 0, 1'b0, "R8 gap6"); endtask

  initial begin
    t_reset();
    set_bank(0, 5, 2, 1, 2, 3, 2, 3, 1, 1);
    set_bank(1, 1, 0, 0, 0, 9, 0, 7, 6, 0);
    set_bank(2, 15, 3, 15, 15, 0, 4, 1, 7, 1);
    set_bank(3, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    t_basic();
    t_clamp();
    t_wait();
    t_wait_off();
    t_ignore();
    t_b2b();
    all_done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!all_done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule